// File: doc/BRIEF.md
# Balancing command frame decoder

This block sits behind a CAN controller inside a cell-monitor node. It looks at every received data frame and keeps only those that carry the balancing command identifier. From an accepted frame it takes a bypass threshold voltage, a per-cell bypass enable pattern and a flag that asks the node chain to renumber itself. The flag is delivered as a one-cycle pulse.

The block also guards the command stream. The first accepted frame after reset arms a gap timer. If the timer ever runs a full allowed interval without a new command frame, the block latches a lockout. While locked out it drops every bypass enable, blocks the renumber pulse and ignores all later frames. Only a reset clears the lockout.

Top module: `bal_cmd_decoder`

## Requirements
- R1: Only frames whose identifier equals `FRAME_ID` (default 11'h3C3) are decoded; a strobe with any other identifier changes no output.
- R2: Data byte k sits at `frmData[8k+7:8k]`, with byte 0 as the first byte on the bus. On each accepted frame, `thresholdMv` becomes `OFFSET_MV` (default 2100) plus the 16-bit value {byte0, byte1}, read big-endian in 1 mV steps. The new value shows one clock after the strobe.
- R3: On each accepted frame, `bypassEn[i]` takes bit i of data byte 4, with bit 0 for the lowest cell. A zero byte clears all enables and so cancels any bypassing in progress.
- R4: An accepted frame with bit 2 of data byte 3 set makes `renumPulse` high for exactly the one clock that follows the strobe. Without that bit there is no pulse.
- R5: Before the first accepted frame after reset the gap timer is not armed, so no idle time can cause lockout.
- R6: Once armed, a frame strobed no more than `GAP_CYCLES` clocks after the previous accepted frame is accepted. If `GAP_CYCLES` clocks pass with no such frame, `lockedOut` rises on that clock and stays high until reset.
- R7: While `lockedOut` is high, `bypassEn` is all zero, `renumPulse` stays low and frames change neither the threshold nor the stored enables.
- R8: During and right after reset, `thresholdMv` equals `OFFSET_MV`, `bypassEn` is zero, `renumPulse` is low and `lockedOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frmValid | input | 1 | One-cycle strobe marking a received frame |
| frmId | input | 11 | Frame identifier |
| frmData | input | 64 | Eight data bytes, byte k at bits 8k+7:8k |
| thresholdMv | output | 17 | Bypass threshold in millivolts |
| bypassEn | output | CELLS | Per-cell bypass enables |
| renumPulse | output | 1 | One-cycle renumber request |
| lockedOut | output | 1 | Sticky lockout flag |

## Verification
A renumber request and the gap lockout can fall on the same clock. This happens when a frame with the renumber bit arrives on the last clock of the allowed interval. The bench sends one frame exactly `GAP_CYCLES` clocks after the previous one and expects both the pulse and no lockout. It then sends a frame one clock past the interval and expects the lockout already high, no pulse and the enables forced to zero. A reference model that counts clocks since the last accepted frame judges these outcomes, and it is compared with the outputs on every clock.

// File: rtl/balcmd_pkg.sv
package balcmd_pkg;
  localparam int BYTE_W       = 8;
  localparam int THR_HI_BYTE  = 0;
  localparam int THR_LO_BYTE  = 1;
  localparam int FLAG_BYTE    = 3;
  localparam int RENUM_BIT    = 2;
  localparam int BYP_BYTE     = 4;
  localparam int CODE_W       = 16;

  typedef struct packed {
    logic loadCmd;
    logic lockout;
  } ctlStrobe_t;
endpackage

// File: rtl/balcmd_ctrl.sv
module balcmd_ctrl
  import balcmd_pkg::*;
#(
  parameter logic [10:0] FRAME_ID   = 11'h3C3,
  parameter int          GAP_CYCLES = 50_000_000
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frmValid,
  input  logic [10:0] frmId,
  output ctlStrobe_t strobes
);
  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(GAP_CYCLES - 1);

  logic idHit;
  logic armed;
  logic locked;
  logic [CNT_W-1:0] gapCnt;

  assign idHit = frmValid && (frmId == FRAME_ID);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      locked <= 1'b0;
      gapCnt <= '0;
    end else begin
      if (idHit) begin
        armed  <= 1'b1;
        gapCnt <= '0;
      end else if (armed && !locked) begin
        gapCnt <= gapCnt + 1'b1;
        if (gapCnt == LAST_IDLE) locked <= 1'b1;
      end
    end
  end

  assign strobes.loadCmd = idHit && !locked;
  assign strobes.lockout = locked;
endmodule

// File: rtl/balcmd_datapath.sv
module balcmd_datapath
  import balcmd_pkg::*;
#(
  parameter int OFFSET_MV = 2100,
  parameter int CELLS     = 8,
  parameter int THR_W     = 17
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [CODE_W-1:0] thrCode,
  input  logic              renumFlag,
  input  logic [CELLS-1:0]  bypassField,
  output logic [THR_W-1:0]  thresholdMv,
  output logic [CELLS-1:0]  bypassEn,
  output logic              renumPulse
);
  localparam logic [THR_W-1:0] BASE_MV = THR_W'(OFFSET_MV);

  logic [CELLS-1:0] bypassReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thresholdMv <= BASE_MV;
      bypassReg   <= '0;
      renumPulse  <= 1'b0;
    end else begin
      renumPulse <= strobes.loadCmd && renumFlag;
      if (strobes.loadCmd) begin
        thresholdMv <= BASE_MV + THR_W'(thrCode);
        bypassReg   <= bypassField;
      end
    end
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cellMask
    assign bypassEn[c] = bypassReg[c] && !strobes.lockout;
  end
endmodule

// File: rtl/bal_cmd_decoder.sv
module bal_cmd_decoder
  import balcmd_pkg::*;
#(
  parameter logic [10:0] FRAME_ID   = 11'h3C3,
  parameter int          OFFSET_MV  = 2100,
  parameter int          CELLS      = 8,
  parameter int          GAP_CYCLES = 50_000_000,
  parameter int          THR_W      = $clog2(OFFSET_MV + (1 << CODE_W))
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmValid,
  input  logic [10:0]      frmId,
  input  logic [63:0]      frmData,
  output logic [THR_W-1:0] thresholdMv,
  output logic [CELLS-1:0] bypassEn,
  output logic             renumPulse,
  output logic             lockedOut
);
  ctlStrobe_t strobes;
  logic [CODE_W-1:0] thrCode;
  logic unusedData;

  assign thrCode = {frmData[THR_HI_BYTE*BYTE_W +: BYTE_W],
                    frmData[THR_LO_BYTE*BYTE_W +: BYTE_W]};
  assign unusedData = ^{frmData[23:16], frmData[31:27], frmData[25:24],
                        frmData[63:32+CELLS]};

  balcmd_ctrl #(.FRAME_ID(FRAME_ID), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmId(frmId),
    .strobes(strobes)
  );

  balcmd_datapath #(.OFFSET_MV(OFFSET_MV), .CELLS(CELLS), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .thrCode(thrCode),
    .renumFlag(frmData[FLAG_BYTE*BYTE_W + RENUM_BIT]),
    .bypassField(frmData[BYP_BYTE*BYTE_W +: CELLS]),
    .thresholdMv(thresholdMv), .bypassEn(bypassEn), .renumPulse(renumPulse)
  );

  assign lockedOut = strobes.lockout;
endmodule

// File: rtl/balcmd_checker.sv
module balcmd_checker #(
  parameter logic [10:0] FRAME_ID  = 11'h3C3,
  parameter int          OFFSET_MV = 2100,
  parameter int          CELLS     = 8,
  parameter int          THR_W     = 17
)(
  input logic             clk,
  input logic             rstN,
  input logic             frmValid,
  input logic [10:0]      frmId,
  input logic             renumBit,
  input logic [THR_W-1:0] thresholdMv,
  input logic [CELLS-1:0] bypassEn,
  input logic             renumPulse,
  input logic             lockedOut
);
  AST_FOREIGN_ID_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    !(frmValid && frmId == FRAME_ID) |=> $stable(thresholdMv)); // R1
  AST_THRESH_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    thresholdMv >= THR_W'(OFFSET_MV)); // R2
  AST_RENUM_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    renumPulse |-> $past(frmValid && frmId == FRAME_ID && renumBit)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |=> lockedOut); // R6
  AST_LOCK_MASKS_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |-> (bypassEn == '0)); // R7
  AST_NO_RENUM_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    renumPulse |-> !$past(lockedOut)); // R7
endmodule

bind bal_cmd_decoder balcmd_checker #(
  .FRAME_ID(FRAME_ID), .OFFSET_MV(OFFSET_MV), .CELLS(CELLS), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmId(frmId),
  .renumBit(frmData[26]), .thresholdMv(thresholdMv), .bypassEn(bypassEn),
  .renumPulse(renumPulse), .lockedOut(lockedOut)
);

// File: tb/bal_cmd_decoder_bench.sv
module bal_cmd_decoder_bench;
  localparam int GAP = 40;
  localparam logic [10:0] ID = 11'h3C3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frmValid = 1'b0;
  logic [10:0] frmId = '0;
  logic [63:0] frmData = '0;
  logic [16:0] thresholdMv;
  logic [7:0]  bypassEn;
  logic        renumPulse;
  logic        lockedOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bal_cmd_decoder #(.GAP_CYCLES(GAP)) u_bal_cmd_decoder (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmId(frmId),
    .frmData(frmData), .thresholdMv(thresholdMv), .bypassEn(bypassEn),
    .renumPulse(renumPulse), .lockedOut(lockedOut)
  );

  // behavioural reference model
  int  mThr, mByp, sinceLast;
  bit  mRen, mLock, mArmed;

  always @(posedge clk) begin
    if (!rstN) begin
      mThr = 2100; mByp = 0; mRen = 0; mLock = 0; mArmed = 0; sinceLast = 0;
    end else begin
      automatic bit hit = frmValid && (frmId == ID);
      automatic bit acc = hit && !mLock;
      mRen = acc && frmData[26];
      if (acc) begin
        mThr = 2100 + int'({frmData[7:0], frmData[15:8]});
        mByp = int'(frmData[39:32]);
      end
      if (hit) begin
        mArmed = 1; sinceLast = 0;
      end else if (mArmed) begin
        sinceLast++;
        if (sinceLast >= GAP) mLock = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(int'(thresholdMv) == mThr, "R2 model threshold", int'(thresholdMv), mThr);
      chk(int'(bypassEn) == (mLock ? 0 : mByp), "R3/R7 model bypass",
          int'(bypassEn), mLock ? 0 : mByp);
      chk(renumPulse == mRen, "R4 model renum", int'(renumPulse), int'(mRen));
      chk(lockedOut == mLock, "R6 model lockout", int'(lockedOut), int'(mLock));
    end
  end

  function automatic logic [63:0] mk(input logic [7:0] b0, input logic [7:0] b1,
                                     input logic [7:0] b3, input logic [7:0] b4);
    return {8'hC3, 8'h3C, 8'h99, b4, b3, 8'h5A, b1, b0};
  endfunction

  // called at a negedge; returns at the negedge after the capture edge
  task automatic sendFrame(input logic [10:0] id, input logic [63:0] d);
    frmValid = 1'b1; frmId = id; frmData = d;
    @(negedge clk);
    frmValid = 1'b0; frmData = '0; frmId = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(thresholdMv == 17'd2100, "R8 reset threshold", int'(thresholdMv), 2100);
    chk(bypassEn == 8'h00, "R8 reset bypass", int'(bypassEn), 0);
    chk(!renumPulse && !lockedOut, "R8 reset flags", int'({renumPulse, lockedOut}), 0);
    rstN = 1'b1;
    idle(3 * GAP);
    chk(!lockedOut, "R5 no lockout before first frame", int'(lockedOut), 0);
    sendFrame(11'h3C2, mk(8'h01, 8'h00, 8'h04, 8'hFF));
    chk(thresholdMv == 17'd2100 && bypassEn == 0 && !renumPulse, "R1 foreign id ignored",
        int'(thresholdMv), 2100);
    sendFrame(ID, mk(8'h01, 8'hF4, 8'h00, 8'hA5));
    chk(thresholdMv == 17'd2600, "R2 threshold 500 code", int'(thresholdMv), 2600);
    chk(bypassEn == 8'hA5, "R3 bypass pattern", int'(bypassEn), 'hA5);
    chk(!renumPulse, "R4 no pulse without flag", int'(renumPulse), 0);
    sendFrame(ID, mk(8'h00, 8'h00, 8'h04, 8'h00));
    chk(renumPulse, "R4 pulse on flag", int'(renumPulse), 1);
    chk(bypassEn == 8'h00, "R3 zero byte cancels bypass", int'(bypassEn), 0);
    chk(thresholdMv == 17'd2100, "R2 zero code", int'(thresholdMv), 2100);
    idle(1);
    chk(!renumPulse, "R4 pulse is one cycle", int'(renumPulse), 0);
    sendFrame(ID, mk(8'hFF, 8'hFF, 8'h00, 8'h0F));
    chk(thresholdMv == 17'd67635, "R2 max code", int'(thresholdMv), 67635);
    idle(GAP - 1);
    chk(!lockedOut, "R6 not locked on last allowed clock", int'(lockedOut), 0);
    sendFrame(ID, mk(8'h00, 8'h10, 8'h04, 8'h3C));
    chk(renumPulse && !lockedOut, "R6 frame at limit accepted with pulse",
        int'({renumPulse, lockedOut}), 2);
    chk(bypassEn == 8'h3C, "R6 bypass at limit", int'(bypassEn), 'h3C);
    idle(GAP);
    chk(lockedOut, "R6 lockout after gap", int'(lockedOut), 1);
    chk(bypassEn == 8'h00, "R7 bypass forced off", int'(bypassEn), 0);
    sendFrame(ID, mk(8'h02, 8'h00, 8'h04, 8'hFF));
    chk(!renumPulse, "R7 no pulse when locked", int'(renumPulse), 0);
    chk(thresholdMv == 17'd2116 && bypassEn == 0, "R7 frame ignored when locked",
        int'(thresholdMv), 2116);
    idle(2 * GAP);
    chk(lockedOut, "R6 lockout sticky", int'(lockedOut), 1);
    rstN = 1'b0;
    @(negedge clk);
    chk(!lockedOut && thresholdMv == 17'd2100, "R8 reset clears lockout",
        int'(lockedOut), 0);
    rstN = 1'b1;
    idle(2);
    sendFrame(ID, mk(8'h00, 8'h64, 8'h00, 8'h81));
    chk(thresholdMv == 17'd2200 && bypassEn == 8'h81, "R2 accepted after reset",
        int'(thresholdMv), 2200);
    idle(3);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule